// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides, at each instruction boundary of a small 8-bit CPU core, whether an interrupt is taken and which 16-bit vector address the core fetches next. The requests it weighs are a pending reset, a software interrupt, the external active-low interrupt pin, three timer flags, two SPI flags and a Port B flag. The timer flags share one vector, and so do the two SPI flags. When an instruction completes, the core raises a one-cycle boundary strobe. One cycle later the block gives a one-cycle take pulse and the vector of the highest-priority request that may be taken. On that pulse the core stacks its state and sets its interrupt mask.

The external pin has two trigger modes, selected by a static option input. In edge mode only a falling edge counts. In level mode a low level also counts. A falling edge is held in an internal request latch until the external interrupt is acknowledged. For a core that is in its wait or stop low-power state, the block also drives two wake-up requests, each drawn from its own set of sources.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While rst_n is low, and afterwards until a boundary strobe is seen, take_int is 0 and vec_addr is 16'h0000.
- R2: The first boundary after reset is taken with vector 16'h1FFE, whatever the value of cpu_imask.
- R3: take_int is asserted only in the cycle after a cycle with instr_done high. vec_addr is 16'h0000 whenever take_int is 0.
- R4: With level_mode=0, a falling edge on irq_pin_n is held until it is taken, even if the pin returns high first. A pin held low after it is taken raises no further request.
- R5: With level_mode=1, a low irq_pin_n requests the external vector 16'h1FFA at every boundary while it stays low. Once the pin is high, no request remains.
- R6: When cpu_imask is 1, the external, timer, SPI and Port B requests are not taken.
- R7: swi_req is taken with vector 16'h1FFC even when cpu_imask is 1.
- R8: Fixed priority, highest first: reset (1FFE), software (1FFC), external (1FFA), timer (1FF8), SPI (1FF6), Port B (1FF4).
- R9: A timer request is the OR of each flag (capture, compare, overflow) ANDed with its own enable. A flag whose enable is 0 has no effect.
- R10: An SPI request is (spi_done OR spi_fault) AND spi_en.
- R11: wake_wait is 1 when cpu_imask is 0 and an external, timer, SPI or Port B request is present.
- R12: wake_stop is 1 when cpu_imask is 0 and one of these is present: an external request, the Port B flag, or a timer request with tmr_ext_clk=1. SPI never wakes from stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low |
| level_mode | input | 1 | 1: edge plus low level; 0: falling edge only |
| tmr_cap_flag | input | 1 | Timer input-capture flag |
| tmr_cmp_flag | input | 1 | Timer output-compare flag |
| tmr_ovf_flag | input | 1 | Timer overflow flag |
| tmr_cap_en | input | 1 | Enable for capture flag |
| tmr_cmp_en | input | 1 | Enable for compare flag |
| tmr_ovf_en | input | 1 | Enable for overflow flag |
| tmr_ext_clk | input | 1 | Timer runs from an external clock |
| spi_done | input | 1 | SPI transfer-complete flag |
| spi_fault | input | 1 | SPI mode-fault flag |
| spi_en | input | 1 | SPI interrupt enable |
| pb_flag | input | 1 | Port B interrupt flag |
| swi_req | input | 1 | Software interrupt executing |
| cpu_imask | input | 1 | CPU interrupt mask bit |
| instr_done | input | 1 | Instruction boundary strobe |
| take_int | output | 1 | One-cycle take pulse |
| vec_addr | output | 16 | Vector address, valid with take_int |
| wake_wait | output | 1 | Wake-up request for wait state |
| wake_stop | output | 1 | Wake-up request for stop state |

## Verification
A request latch that gets stuck set shows at the very next boundary: an extra 1FFA take appears in edge mode, and wake_wait stays high once the pin has gone back high. A latch that never sets shows as a missing take after an edge that came between boundaries. A priority or vector-table fault appears on the single take pulse one cycle after the strobe. Wrong mask gating or wrong wake sets show on the same cycle's wake outputs, or at the next boundary.

// File: rtl/irq_vector_pkg.sv
// Package: shared source indices and vector geometry for the interrupt controller.
// Assumes a 16-bit address space with vectors packed downward from the top word pair.
package irq_vector_pkg;
    localparam int ADDR_W   = 16;
    localparam int NUM_SRC  = 6;
    localparam logic [ADDR_W-1:0] VEC_TOP = 16'h1FFE;

    // Source index equals priority rank, 0 highest.
    typedef enum logic [2:0] {
        SRC_RST = 3'd0,
        SRC_SWI = 3'd1,
        SRC_EXT = 3'd2,
        SRC_TMR = 3'd3,
        SRC_SPI = 3'd4,
        SRC_PB  = 3'd5
    } src_e;

    // Vector for a rank: two bytes below the previous rank.
    function automatic logic [ADDR_W-1:0] vec_of(input int rank);
        return VEC_TOP - ADDR_W'(2 * rank);
    endfunction
endpackage

// File: rtl/ivc_ext_trigger.sv
// Module: external pin trigger. Detects falling edges on an active-low pin,
// holds them in a request latch, and adds a level term in level mode.
// Assumes the pin is already synchronous to clk.
module ivc_ext_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic level_mode,
    input  logic ack,
    output logic pending
);
    logic pin_q;
    logic req_latch;
    logic fall;

    // Falling edge relative to last sampled pin value.
    assign fall = pin_q & ~pin_n;

    // Track previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n;
    end

    // Request latch: set on edge, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    req_latch <= 1'b0;
        else if (ack)  req_latch <= 1'b0;
        else if (fall) req_latch <= 1'b1;
    end

    // Level mode keeps requesting while pin is low.
    assign pending = req_latch | (level_mode & ~pin_n);
endmodule

// File: rtl/ivc_arbiter.sv
// Module: fixed-priority arbiter. At a boundary strobe picks the lowest-index
// active request, registers a take pulse and the vector, and returns a
// combinational one-hot acknowledge for the winner.
// Assumes requests are already gated by the mask where required.
module ivc_arbiter
    import irq_vector_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic [N-1:0]      req,
    output logic [N-1:0]      ack,
    output logic              take,
    output logic [ADDR_W-1:0] vec
);
    logic [N-1:0]      win;
    logic [ADDR_W-1:0] win_vec;

    // Walk from lowest to highest priority so the highest wins.
    always_comb begin
        win     = '0;
        win_vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win     = '0;
                win[i]  = 1'b1;
                win_vec = vec_of(i);
            end
        end
    end

    assign ack = boundary ? win : '0;

    // Register take pulse and vector one cycle after the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take <= 1'b0;
            vec  <= '0;
        end else begin
            take <= boundary & (|req);
            vec  <= boundary ? win_vec : '0;
        end
    end
endmodule

// File: rtl/ivc_wake.sv
// Module: low-power wake decode. Wait wakes on any unmasked hardware request;
// stop wakes only on sources that run without the core clock.
module ivc_wake (
    input  logic imask,
    input  logic ext_req,
    input  logic tmr_req,
    input  logic spi_req,
    input  logic pb_req,
    input  logic tmr_ext_clk,
    output logic wake_wait,
    output logic wake_stop
);
    // Combine source sets per low-power state.
    always_comb begin
        wake_wait = ~imask & (ext_req | tmr_req | spi_req | pb_req);
        wake_stop = ~imask & (ext_req | pb_req | (tmr_req & tmr_ext_clk));
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the prioritized interrupt vector controller. Collects the
// per-peripheral requests, applies the CPU mask to hardware sources, and
// drives arbitration and wake decode. Assumes instr_done is a one-cycle strobe.
module irq_vector_ctrl
    import irq_vector_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic              level_mode,
    input  logic              tmr_cap_flag,
    input  logic              tmr_cmp_flag,
    input  logic              tmr_ovf_flag,
    input  logic              tmr_cap_en,
    input  logic              tmr_cmp_en,
    input  logic              tmr_ovf_en,
    input  logic              tmr_ext_clk,
    input  logic              spi_done,
    input  logic              spi_fault,
    input  logic              spi_en,
    input  logic              pb_flag,
    input  logic              swi_req,
    input  logic              cpu_imask,
    input  logic              instr_done,
    output logic              take_int,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake_wait,
    output logic              wake_stop
);
    logic               rst_pend;
    logic               ext_pend;
    logic               tmr_req;
    logic               spi_req;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] gated_req;
    logic [NUM_SRC-1:0] ack;

    // Reset vector stays pending until the first boundary takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_pend <= 1'b1;
        else if (ack[SRC_RST]) rst_pend <= 1'b0;
    end

    ivc_ext_trigger u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (irq_pin_n),
        .level_mode (level_mode),
        .ack        (ack[SRC_EXT]),
        .pending    (ext_pend)
    );

    // Shared-vector request formation.
    always_comb begin
        tmr_req = (tmr_cap_flag & tmr_cap_en) | (tmr_cmp_flag & tmr_cmp_en)
                | (tmr_ovf_flag & tmr_ovf_en);
        spi_req = (spi_done | spi_fault) & spi_en;
    end

    // Request vector in rank order.
    always_comb begin
        raw_req          = '0;
        raw_req[SRC_RST] = rst_pend;
        raw_req[SRC_SWI] = swi_req;
        raw_req[SRC_EXT] = ext_pend;
        raw_req[SRC_TMR] = tmr_req;
        raw_req[SRC_SPI] = spi_req;
        raw_req[SRC_PB]  = pb_flag;
    end

    // Mask applies only to hardware ranks; reset and software pass through.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        if (g <= int'(SRC_SWI)) begin : g_unmasked
            assign gated_req[g] = raw_req[g];
        end else begin : g_masked
            assign gated_req[g] = raw_req[g] & ~cpu_imask;
        end
    end

    ivc_arbiter #(.N(NUM_SRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (instr_done),
        .req      (gated_req),
        .ack      (ack),
        .take     (take_int),
        .vec      (vec_addr)
    );

    ivc_wake u_wake (
        .imask       (cpu_imask),
        .ext_req     (ext_pend),
        .tmr_req     (tmr_req),
        .spi_req     (spi_req),
        .pb_req      (pb_flag),
        .tmr_ext_clk (tmr_ext_clk),
        .wake_wait   (wake_wait),
        .wake_stop   (wake_stop)
    );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module: property checker bound to the controller top.
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_done,
    input logic        cpu_imask,
    input logic        swi_req,
    input logic        take_int,
    input logic [15:0] vec_addr,
    input logic        wake_wait,
    input logic        wake_stop
);
    // R3: take only follows a boundary strobe.
    p_take_after_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> $past(instr_done));

    // R3: vector is zero while no take.
    p_vec_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_int |-> vec_addr == 16'h0000);

    // R8: every taken vector lies in the table.
    p_vec_in_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> (vec_addr[15:4] == 12'h1FF && vec_addr[0] == 1'b0
                      && vec_addr[3:1] >= 3'd2));

    // R6: with mask set, only reset or software vectors are taken.
    p_mask_blocks_hw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && $past(cpu_imask)) |-> (vec_addr == 16'h1FFE || vec_addr == 16'h1FFC));

    // R7: software request at a boundary is always taken.
    p_swi_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && swi_req) |=> take_int);

    // R12: every stop wake source is also a wait wake source.
    p_stop_subset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_stop |-> wake_wait);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .cpu_imask  (cpu_imask),
    .swi_req    (swi_req),
    .take_int   (take_int),
    .vec_addr   (vec_addr),
    .wake_wait  (wake_wait),
    .wake_stop  (wake_stop)
);

// File: tb/irq_vector_ctrl_tb_top.sv
// Bench: table walk of boundary arbitration cases, then directed tests.
module irq_vector_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_pin_n = 1'b1, level_mode = 1'b0;
    logic tmr_cap_flag = 0, tmr_cmp_flag = 0, tmr_ovf_flag = 0;
    logic tmr_cap_en = 0, tmr_cmp_en = 0, tmr_ovf_en = 0, tmr_ext_clk = 0;
    logic spi_done = 0, spi_fault = 0, spi_en = 0, pb_flag = 0;
    logic swi_req = 0, cpu_imask = 0, instr_done = 0;
    logic take_int, wake_wait, wake_stop;
    logic [15:0] vec_addr;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl dut_i (.*);

    typedef struct packed {
        logic pin_n;
        logic cf, mf, of, ce, me, oe;
        logic sd, sf, se;
        logic pb, swi, msk;
        logic take;
        logic [15:0] vec;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 1,0,0, 1,0,0, 0,0,0, 0,0,0, 1'b1, 16'h1FF8}, // R9 capture
        '{1'b1, 0,1,0, 0,0,1, 0,0,0, 0,0,0, 1'b0, 16'h0000}, // R9 no enable
        '{1'b1, 0,0,1, 0,0,1, 1,0,1, 0,0,0, 1'b1, 16'h1FF8}, // R8 timer > SPI
        '{1'b1, 0,0,0, 0,0,0, 0,1,1, 1,0,0, 1'b1, 16'h1FF6}, // R10 fault, R8 SPI > PB
        '{1'b1, 0,0,0, 0,0,0, 1,0,0, 1,0,0, 1'b1, 16'h1FF4}, // R10 no enable; PB
        '{1'b1, 0,0,0, 0,0,0, 0,0,0, 1,0,1, 1'b0, 16'h0000}, // R6 masked PB
        '{1'b1, 0,0,0, 0,0,0, 0,0,0, 0,1,1, 1'b1, 16'h1FFC}, // R7 SWI masked
        '{1'b1, 1,0,0, 1,0,0, 0,0,0, 0,1,0, 1'b1, 16'h1FFC}, // R8 SWI > timer
        '{1'b0, 1,0,0, 1,0,0, 0,0,0, 0,0,0, 1'b1, 16'h1FFA}, // R8 ext > timer
        '{1'b1, 1,0,0, 1,0,0, 0,0,0, 0,0,1, 1'b0, 16'h0000}  // R6 masked timer
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulse a boundary, then sample the take pulse one cycle later.
    task automatic boundary(input string tag, input logic exp_take, input logic [15:0] exp_vec);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        check({tag, " take"}, {15'b0, take_int}, {15'b0, exp_take});
        check({tag, " vec"}, vec_addr, exp_vec);
    endtask

    task automatic clear_inputs();
        {tmr_cap_flag, tmr_cmp_flag, tmr_ovf_flag, tmr_cap_en, tmr_cmp_en, tmr_ovf_en} = '0;
        {spi_done, spi_fault, spi_en, pb_flag, swi_req, cpu_imask, tmr_ext_clk} = '0;
        irq_pin_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset.
        check("R1 reset take", {15'b0, take_int}, 16'h0);
        check("R1 reset vec", vec_addr, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle after reset", {15'b0, take_int}, 16'h0);
        // R2: reset vector taken even with mask set.
        cpu_imask = 1'b1;
        boundary("R2 reset vector", 1'b1, 16'h1FFE);
        boundary("R2 reset once", 1'b0, 16'h0000);
        cpu_imask = 1'b0;
        @(negedge clk);

        // Table walk: R6..R10.
        for (int i = 0; i < NROWS; i++) begin
            irq_pin_n = TBL[i].pin_n;
            {tmr_cap_flag, tmr_cmp_flag, tmr_ovf_flag} = {TBL[i].cf, TBL[i].mf, TBL[i].of};
            {tmr_cap_en, tmr_cmp_en, tmr_ovf_en} = {TBL[i].ce, TBL[i].me, TBL[i].oe};
            {spi_done, spi_fault, spi_en} = {TBL[i].sd, TBL[i].sf, TBL[i].se};
            {pb_flag, swi_req, cpu_imask} = {TBL[i].pb, TBL[i].swi, TBL[i].msk};
            @(negedge clk);
            boundary($sformatf("R8 row %0d", i), TBL[i].take, TBL[i].vec);
            clear_inputs();
            @(negedge clk);
        end

        // R3: no strobe, no take.
        pb_flag = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 no boundary", {15'b0, take_int}, 16'h0);
        pb_flag = 1'b0;

        // R4: edge held across pin release while masked, taken once unmasked.
        cpu_imask = 1'b1;
        irq_pin_n = 1'b0;
        @(negedge clk);
        irq_pin_n = 1'b1;
        @(negedge clk);
        boundary("R4 masked edge", 1'b0, 16'h0000);
        cpu_imask = 1'b0;
        @(negedge clk);
        check("R11 latched ext wakes wait", {15'b0, wake_wait}, 16'h1);
        boundary("R4 latched edge", 1'b1, 16'h1FFA);
        boundary("R4 cleared after take", 1'b0, 16'h0000);
        // R4: held low in edge mode gives one take only.
        irq_pin_n = 1'b0;
        @(negedge clk);
        boundary("R4 held low first", 1'b1, 16'h1FFA);
        boundary("R4 held low no retrigger", 1'b0, 16'h0000);
        irq_pin_n = 1'b1;
        @(negedge clk);

        // R5: level mode repeats while low.
        level_mode = 1'b1;
        irq_pin_n = 1'b0;
        @(negedge clk);
        boundary("R5 level first", 1'b1, 16'h1FFA);
        boundary("R5 level repeat", 1'b1, 16'h1FFA);
        irq_pin_n = 1'b1;
        @(negedge clk);
        boundary("R5 level released", 1'b0, 16'h0000);
        level_mode = 1'b0;

        // R11/R12: wake sets.
        spi_done = 1'b1; spi_en = 1'b1;
        @(negedge clk);
        check("R11 SPI wakes wait", {15'b0, wake_wait}, 16'h1);
        check("R12 SPI no stop wake", {15'b0, wake_stop}, 16'h0);
        clear_inputs();
        tmr_ovf_flag = 1'b1; tmr_ovf_en = 1'b1;
        @(negedge clk);
        check("R12 timer internal clk", {15'b0, wake_stop}, 16'h0);
        tmr_ext_clk = 1'b1;
        @(negedge clk);
        check("R12 timer external clk", {15'b0, wake_stop}, 16'h1);
        cpu_imask = 1'b1;
        @(negedge clk);
        check("R11 mask blocks wait wake", {15'b0, wake_wait}, 16'h0);
        clear_inputs();
        pb_flag = 1'b1;
        @(negedge clk);
        check("R12 PB wakes stop", {15'b0, wake_stop}, 16'h1);
        clear_inputs();
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule